// File: doc/BRIEF.md
# Memory Card Bring-Up Sequencer

This block is a control state machine that takes a removable memory card from power-up to a selected state with its bus running at the faster clock. It does not drive the card lines. It hands each command to a separate command/response engine through a request/response handshake. A request carries a command index, a 32-bit argument, a command-attribute word and an expected response type. The engine returns one response-valid or timeout pulse with up to six response bytes.

The sequencer reads the returned bytes to choose between two paths. On the card type handled here, it polls the operating-condition command with a bounded retry count and a programmable wait between attempts. It records whether the card came ready and whether it is a high-capacity part. It then moves the card clock divider from the slow rate to the fast rate, selects the card, issues the final switch command and waits for the programming-done status bit, which it clears with a one-cycle pulse. When the other card type answers the application-prefix probe, the block pulses a hand-off strobe and returns to idle for another controller to carry on.

Top module: `card_bringup_seq`

## Requirements
- R1: After reset, the outputs are `req_valid`=0, `done`=0, `ok`=0, `high_cap`=0, `prg_clr`=0, `sd_handoff`=0 and `clk_div`=7. A `start` pulse accepted in idle clears `done`, `ok` and `high_cap` and sets `clk_div` back to 7.
- R2: After `start`, the first four requests are, in order: index 12 (arg 0, attr 0x41, type 1), index 0 (arg 0, attr 0x80, type 0), index 8 (arg 0x1AA, attr 0x01, type 1) and index 55 (arg 0, attr 0x01, type 1). Type codes are: 0 no response, 1 short, 2 long identification, 3 operating-condition.
- R3: While `req_ready` is low, `req_valid` stays high and the request fields stay stable. No new request is raised until the engine returns `rsp_valid` or `rsp_timeout` for the accepted one.
- R4: Response byte k is `rsp_data[8k+7:8k]`, and a timeout makes all bytes read as zero. If the index-55 response has byte 0 bit 5 set, or byte 5 equal to 0x37, the block pulses `sd_handoff` for one cycle and returns to idle with `done` low. Otherwise it continues.
- R5: The first operating-condition request is index 1, arg 0x40FF8000, attr 0x03, type 3. While byte 4 bit 7 of the response is clear, the request is repeated with arg 0x40300000.
- R6: At most 500 repeats follow the first operating-condition request (parameter MAX_RETRY). A timeout counts as an attempt whose ready bit is clear.
- R7: Between a not-ready operating-condition response and the next repeat request, at least `delay_cycles` clock cycles pass.
- R8: When polling ends, `ok` takes byte 4 bit 7 of the last response. `high_cap` is 1 exactly when (byte 4 AND 0x60) equals 0x40. Both values hold while `done` is high.
- R9: After polling, the block issues index 2 (arg 0, attr 0x02, type 2) and then index 3 (arg 0x10, attr 0x01, type 1), whatever the value of `ok`.
- R10: `clk_div` stays 7 through the index-3 exchange. It is 2 before the index-7 request (arg 0x10, attr 0x01, type 1) is raised.
- R11: Index 6 (arg 0x03B70101, attr 0x441, type 1) is the last request. The block then holds `done` low until `prg_done` is seen, pulses `prg_clr` for one cycle, and then raises `done`.
- R12: `start` is ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up sequence (taken in idle only) |
| delay_cycles | input | 16 | Wait between operating-condition attempts, in cycles |
| req_valid | output | 1 | Command request pending |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| req_attr | output | 16 | Command-attribute word |
| req_rtype | output | 3 | Expected response type |
| req_ready | input | 1 | Engine accepts the pending request |
| rsp_valid | input | 1 | Response received pulse |
| rsp_timeout | input | 1 | No response pulse |
| rsp_data | input | 48 | Response bytes, byte 0 in the low bits |
| prg_done | input | 1 | Programming-done status bit |
| prg_clr | output | 1 | Write-one pulse clearing programming-done |
| clk_div | output | 4 | Card clock divider setting |
| sd_handoff | output | 1 | Strobe: the other card type answered |
| done | output | 1 | Sequence finished |
| ok | output | 1 | Card reported ready |
| high_cap | output | 1 | Card is high-capacity |

## Verification
The assertions assume a well-behaved engine. It raises `req_ready` only against a pending request, and it sends exactly one response or timeout pulse per accepted command, never while no command is outstanding. They also assume `prg_done` rises only after the switch command. The bench's responder task enforces these rules: it waits for `req_valid`, accepts after a random 0 to 2 cycle hold, and answers after 1 to 3 cycles. Random stimulus varies the poll length, the delay, the ready byte and any timeouts within these rules. Directed runs cover the exhausted poll, both hand-off triggers and a stray `start`.

// File: rtl/card_bringup_pkg.sv
package card_bringup_pkg;
  localparam int IDX_W     = 6;
  localparam int ARG_W     = 32;
  localparam int ATTR_W    = 16;
  localparam int RT_W      = 3;
  localparam int RSP_BYTES = 6;
  localparam int RSP_W     = 8 * RSP_BYTES;

  // byte positions the decode depends on
  localparam int FLAG_BYTE = 0;
  localparam int ECHO_BYTE = 5;
  localparam int OCR_BYTE  = 4;
  localparam logic [7:0] ECHO_VAL = 8'h37;

  localparam logic [RT_W-1:0] RT_NONE  = 3'd0;
  localparam logic [RT_W-1:0] RT_SHORT = 3'd1;
  localparam logic [RT_W-1:0] RT_LONG  = 3'd2;
  localparam logic [RT_W-1:0] RT_OCR   = 3'd3;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [ARG_W-1:0]  arg;
    logic [ATTR_W-1:0] attr;
    logic [RT_W-1:0]   rtype;
  } cmd_t;

  typedef enum logic [3:0] {
    STP_STOP, STP_RESET, STP_IFCOND, STP_APP, STP_OCR_FIRST,
    STP_OCR_AGAIN, STP_CID, STP_RCA, STP_SELECT, STP_SWITCH
  } step_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LAUNCH, PH_WAIT, PH_DELAY, PH_PRG, PH_FIN
  } phase_e;

  function automatic cmd_t mk_cmd(input int i, input logic [ARG_W-1:0] a,
                                  input logic [ATTR_W-1:0] t, input logic [RT_W-1:0] r);
    cmd_t c;
    c.idx   = IDX_W'(i);
    c.arg   = a;
    c.attr  = t;
    c.rtype = r;
    return c;
  endfunction

  function automatic cmd_t cmd_for(input step_e s);
    case (s)
      STP_STOP:      return mk_cmd(12, 32'h0,        16'h0041, RT_SHORT);
      STP_RESET:     return mk_cmd(0,  32'h0,        16'h0080, RT_NONE);
      STP_IFCOND:    return mk_cmd(8,  32'h0000_01AA, 16'h0001, RT_SHORT);
      STP_APP:       return mk_cmd(55, 32'h0,        16'h0001, RT_SHORT);
      STP_OCR_FIRST: return mk_cmd(1,  32'h40FF_8000, 16'h0003, RT_OCR);
      STP_OCR_AGAIN: return mk_cmd(1,  32'h4030_0000, 16'h0003, RT_OCR);
      STP_CID:       return mk_cmd(2,  32'h0,        16'h0002, RT_LONG);
      STP_RCA:       return mk_cmd(3,  32'h0000_0010, 16'h0001, RT_SHORT);
      STP_SELECT:    return mk_cmd(7,  32'h0000_0010, 16'h0001, RT_SHORT);
      default:       return mk_cmd(6,  32'h03B7_0101, 16'h0441, RT_SHORT);
    endcase
  endfunction
endpackage

// File: rtl/card_cmd_port.sv
module card_cmd_port
  import card_bringup_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  cmd_t             cmd_in,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic             rsp_timeout,
  input  logic [RSP_W-1:0] rsp_data,
  output logic             req_valid,
  output cmd_t             req_cmd,
  output logic             busy,
  output logic             fin,
  output logic [RSP_W-1:0] rsp_q
);
  logic waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_cmd   <= '0;
      waiting   <= 1'b0;
      fin       <= 1'b0;
      rsp_q     <= '0;
    end else begin
      fin <= 1'b0;
      if (launch) begin
        req_valid <= 1'b1;
        req_cmd   <= cmd_in;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        waiting   <= 1'b1;
      end else if (waiting && (rsp_valid || rsp_timeout)) begin
        waiting <= 1'b0;
        fin     <= 1'b1;
        rsp_q   <= rsp_timeout ? '0 : rsp_data;
      end
    end
  end

  assign busy = req_valid | waiting | fin;

  // R3: request held stable until accepted
  p_hold_until_ready_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_cmd));

  // R3: one command outstanding at a time
  p_single_outstanding_r3: assert property (@(posedge clk) disable iff (rst)
    launch |-> !busy);
endmodule

// File: rtl/card_poll_timer.sv
module card_poll_timer #(
  parameter int MAX_RETRY = 500,
  parameter int DLY_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             consume,
  input  logic             dly_load,
  input  logic [DLY_W-1:0] dly_len,
  output logic             exhausted,
  output logic             dly_zero
);
  localparam int RW = $clog2(MAX_RETRY + 1);

  logic [RW-1:0]    retries;
  logic [DLY_W-1:0] dly_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      retries <= '0;
      dly_cnt <= '0;
    end else begin
      if (arm)
        retries <= RW'(MAX_RETRY);
      else if (consume && retries != '0)
        retries <= retries - 1'b1;
      if (dly_load)
        dly_cnt <= dly_len;
      else if (dly_cnt != '0)
        dly_cnt <= dly_cnt - 1'b1;
    end
  end

  assign exhausted = (retries == '0);
  assign dly_zero  = (dly_cnt == '0);

  // R6: a repeat is only launched while budget remains
  p_retry_budget_r6: assert property (@(posedge clk) disable iff (rst)
    consume |-> !exhausted);

  // R6: budget never above its bound
  p_retry_bound_r6: assert property (@(posedge clk) disable iff (rst)
    retries <= RW'(MAX_RETRY));
endmodule

// File: rtl/card_rsp_fields.sv
module card_rsp_fields
  import card_bringup_pkg::*;
(
  input  logic [RSP_W-1:0] rsp,
  output logic             is_sd,
  output logic             ocr_ready,
  output logic             is_hc
);
  logic [7:0] flag_b, echo_b, ocr_b;
  logic       unused_rsp;

  assign flag_b = rsp[8*FLAG_BYTE +: 8];
  assign echo_b = rsp[8*ECHO_BYTE +: 8];
  assign ocr_b  = rsp[8*OCR_BYTE +: 8];
  assign unused_rsp = ^rsp;

  assign is_sd     = flag_b[5] || (echo_b == ECHO_VAL);
  assign ocr_ready = ocr_b[7];
  assign is_hc     = (ocr_b & 8'h60) == 8'h40;
endmodule

// File: rtl/card_bringup_seq.sv
module card_bringup_seq
  import card_bringup_pkg::*;
#(
  parameter int MAX_RETRY = 500,
  parameter int DLY_W     = 16,
  parameter int DIV_W     = 4,
  parameter int DIV_SLOW  = 7,
  parameter int DIV_FAST  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DLY_W-1:0]  delay_cycles,
  output logic              req_valid,
  output logic [IDX_W-1:0]  req_index,
  output logic [ARG_W-1:0]  req_arg,
  output logic [ATTR_W-1:0] req_attr,
  output logic [RT_W-1:0]   req_rtype,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_timeout,
  input  logic [RSP_W-1:0]  rsp_data,
  input  logic              prg_done,
  output logic              prg_clr,
  output logic [DIV_W-1:0]  clk_div,
  output logic              sd_handoff,
  output logic              done,
  output logic              ok,
  output logic              high_cap
);
  localparam logic [DIV_W-1:0] SLOW = DIV_W'(DIV_SLOW);
  localparam logic [DIV_W-1:0] FAST = DIV_W'(DIV_FAST);

  phase_e     phase;
  step_e      step;
  cmd_t       req_cmd;
  logic       launch, busy, fin;
  logic [RSP_W-1:0] rsp_q;
  logic       is_sd, ocr_ready, is_hc;
  logic       exhausted, dly_zero;
  logic       in_poll, poll_fin, arm, consume, dly_load;

  assign launch   = (phase == PH_LAUNCH);
  assign in_poll  = (step == STP_OCR_FIRST) || (step == STP_OCR_AGAIN);
  assign poll_fin = (phase == PH_WAIT) && fin && in_poll;
  assign arm      = (phase == PH_WAIT) && fin && (step == STP_APP) && !is_sd;
  assign consume  = launch && (step == STP_OCR_AGAIN);
  assign dly_load = poll_fin && !ocr_ready && !exhausted;

  card_cmd_port u_port (
    .clk(clk), .rst(rst), .launch(launch), .cmd_in(cmd_for(step)),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout),
    .rsp_data(rsp_data), .req_valid(req_valid), .req_cmd(req_cmd),
    .busy(busy), .fin(fin), .rsp_q(rsp_q)
  );

  card_rsp_fields u_fields (
    .rsp(rsp_q), .is_sd(is_sd), .ocr_ready(ocr_ready), .is_hc(is_hc)
  );

  card_poll_timer #(.MAX_RETRY(MAX_RETRY), .DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .arm(arm), .consume(consume),
    .dly_load(dly_load), .dly_len(delay_cycles),
    .exhausted(exhausted), .dly_zero(dly_zero)
  );

  assign req_index = req_cmd.idx;
  assign req_arg   = req_cmd.arg;
  assign req_attr  = req_cmd.attr;
  assign req_rtype = req_cmd.rtype;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      step       <= STP_STOP;
      done       <= 1'b0;
      ok         <= 1'b0;
      high_cap   <= 1'b0;
      clk_div    <= SLOW;
      prg_clr    <= 1'b0;
      sd_handoff <= 1'b0;
    end else begin
      prg_clr    <= 1'b0;
      sd_handoff <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          done     <= 1'b0;
          ok       <= 1'b0;
          high_cap <= 1'b0;
          clk_div  <= SLOW;
          step     <= STP_STOP;
          phase    <= PH_LAUNCH;
        end
        PH_LAUNCH: phase <= PH_WAIT;
        PH_WAIT: if (fin) begin
          phase <= PH_LAUNCH;
          case (step)
            STP_STOP:   step <= STP_RESET;
            STP_RESET:  step <= STP_IFCOND;
            STP_IFCOND: step <= STP_APP;
            STP_APP: begin
              if (is_sd) begin
                sd_handoff <= 1'b1;
                phase      <= PH_IDLE;
              end else begin
                step <= STP_OCR_FIRST;
              end
            end
            STP_OCR_FIRST, STP_OCR_AGAIN: begin
              if (ocr_ready || exhausted) begin
                ok       <= ocr_ready;
                high_cap <= is_hc;
                step     <= STP_CID;
              end else begin
                step  <= STP_OCR_AGAIN;
                phase <= PH_DELAY;
              end
            end
            STP_CID: step <= STP_RCA;
            STP_RCA: begin
              clk_div <= FAST;
              step    <= STP_SELECT;
            end
            STP_SELECT: step <= STP_SWITCH;
            default:    phase <= PH_PRG;
          endcase
        end
        PH_DELAY: if (dly_zero) phase <= PH_LAUNCH;
        PH_PRG: if (prg_done) begin
          prg_clr <= 1'b1;
          phase   <= PH_FIN;
        end
        PH_FIN: begin
          done  <= 1'b1;
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R10: divider moves to fast only after the address exchange, back to slow only from idle
  p_div_change_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_div) |-> (clk_div == FAST && $past(step) == STP_RCA) ||
                          (clk_div == SLOW && $past(phase) == PH_IDLE));

  // R10: select request always goes out at the fast rate
  p_select_fast_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_index == IDX_W'(7) |-> clk_div == FAST);

  // R11: clear pulse follows an observed programming-done, before done
  p_prg_clr_r11: assert property (@(posedge clk) disable iff (rst)
    prg_clr |-> $past(prg_done) && !done);

  // R4: hand-off leaves the block idle without completion
  p_handoff_r4: assert property (@(posedge clk) disable iff (rst)
    sd_handoff |-> !done && !req_valid && phase == PH_IDLE);

  // R8: results frozen while done is shown
  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    done && $past(done) |-> $stable(ok) && $stable(high_cap));

  // R12: no new sequence begins while one runs
  p_no_restart_r12: assert property (@(posedge clk) disable iff (rst)
    launch && step == STP_STOP |-> $past(phase) == PH_IDLE);
endmodule

// File: tb/card_bringup_seq_bench.sv
`timescale 1ns/1ps
module card_bringup_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] delay_cycles = '0;
  logic        req_valid;
  logic [5:0]  req_index;
  logic [31:0] req_arg;
  logic [15:0] req_attr;
  logic [2:0]  req_rtype;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic        rsp_timeout = 1'b0;
  logic [47:0] rsp_data = '0;
  logic        prg_done = 1'b0;
  logic        prg_clr;
  logic [3:0]  clk_div;
  logic        sd_handoff, done, ok, high_cap;

  localparam int MAXR = 500;

  int n_chk = 0;
  int n_fail = 0;
  int last_gap = 0;
  bit wd_hit = 0;

  always #2.5 clk = ~clk;

  card_bringup_seq u_card_bringup_seq (
    .clk(clk), .rst(rst), .start(start), .delay_cycles(delay_cycles),
    .req_valid(req_valid), .req_index(req_index), .req_arg(req_arg),
    .req_attr(req_attr), .req_rtype(req_rtype), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_data(rsp_data),
    .prg_done(prg_done), .prg_clr(prg_clr), .clk_div(clk_div),
    .sd_handoff(sd_handoff), .done(done), .ok(ok), .high_cap(high_cap)
  );

  function automatic bit exp_ready(input logic [7:0] b4); return b4[7]; endfunction
  function automatic bit exp_hc(input logic [7:0] b4); return (b4 & 8'h60) == 8'h40; endfunction

  task automatic chk(input bit c, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // engine model: accept one request, then answer it
  task automatic serve(input logic [5:0] ei, input logic [31:0] ea, input logic [15:0] et,
                       input logic [2:0] er, input logic [47:0] d, input bit tmo, input string rq);
    int w = 0;
    logic [56:0] exp_f, got_f;
    while (!req_valid && w < 5000) begin @(negedge clk); w++; end
    last_gap = w;
    exp_f = {ei, ea, et, er};
    got_f = {req_index, req_arg, req_attr, req_rtype};
    chk(req_valid && got_f == exp_f, rq, "request fields", {6'd0, req_valid, got_f}, {7'd1, exp_f});
    for (int h = 0; h < int'($urandom_range(0, 2)); h++) begin
      @(negedge clk);
      chk(req_valid && {req_index, req_arg, req_attr, req_rtype} == got_f, "R3", "held request",
          {req_index, req_arg, req_attr, req_rtype}, got_f);
    end
    req_ready = 1'b1;
    @(negedge clk) req_ready = 1'b0;
    chk(!req_valid, "R3", "valid drops on accept", req_valid, 0);
    for (int h = 0; h < int'($urandom_range(1, 3)); h++) begin
      @(negedge clk);
      chk(!req_valid, "R3", "no request before response", req_valid, 0);
    end
    rsp_valid = !tmo; rsp_timeout = tmo; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_timeout = 1'b0;
  endtask

  task automatic run_mmc(input int n_not, input logic [7:0] fin_b4, input int dly,
                         input bit rnd_tmo, input bit poke);
    logic [47:0] d;
    logic [7:0]  b4, eff_b4;
    bit          rdy, tmo;
    delay_cycles = 16'(dly);
    pulse_start();
    serve(6'd12, 32'h0, 16'h0041, 3'd1, {$urandom, 16'($urandom)}, rnd_tmo && ($urandom_range(0, 1) == 1), "R2");
    chk(clk_div == 4'd7 && !done && !ok && !high_cap, "R1", "state after start",
        {clk_div, done, ok, high_cap}, {4'd7, 3'd0});
    serve(6'd0, 32'h0, 16'h0080, 3'd0, 48'h0, 1'b1, "R2");
    if (poke) pulse_start();  // R12: stray start while running
    serve(6'd8, 32'h1AA, 16'h0001, 3'd1, {$urandom, 16'($urandom)}, 1'b0, "R2");
    if (poke) chk(1'b1, "R12", "stray start ignored", 0, 0);
    d = {$urandom, 16'($urandom)};
    d[5] = 1'b0;
    if (d[47:40] == 8'h37) d[47:40] = 8'h36;
    serve(6'd55, 32'h0, 16'h0001, 3'd1, d, rnd_tmo && ($urandom_range(0, 3) == 0), "R4");
    eff_b4 = 8'h00;
    for (int a = 0; a <= MAXR; a++) begin
      rdy = (a == n_not);
      b4  = rdy ? fin_b4 : (8'($urandom) & 8'h7F);
      tmo = !rdy && rnd_tmo && ($urandom_range(0, 3) == 0);
      d   = {$urandom, 16'($urandom)};
      d[39:32] = b4;
      serve(6'd1, (a == 0) ? 32'h40FF8000 : 32'h40300000, 16'h0003, 3'd3, d, tmo,
            (a == 0) ? "R5" : "R6");
      if (a > 0) chk(last_gap >= dly, "R7", "gap before repeat", last_gap, dly);
      eff_b4 = tmo ? 8'h00 : b4;
      if (rdy) break;
    end
    serve(6'd2, 32'h0, 16'h0002, 3'd2, {$urandom, 16'($urandom)}, 1'b0, "R9");
    chk(ok == exp_ready(eff_b4) && high_cap == exp_hc(eff_b4), "R8", "ok/high_cap",
        {ok, high_cap}, {exp_ready(eff_b4), exp_hc(eff_b4)});
    chk(clk_div == 4'd7, "R10", "slow divider before address", clk_div, 7);
    serve(6'd3, 32'h10, 16'h0001, 3'd1, {$urandom, 16'($urandom)}, 1'b0, "R9");
    for (int w = 0; w < 50 && !req_valid; w++) @(negedge clk);
    chk(clk_div == 4'd2, "R10", "fast divider at select", clk_div, 2);
    serve(6'd7, 32'h10, 16'h0001, 3'd1, {$urandom, 16'($urandom)}, 1'b0, "R10");
    serve(6'd6, 32'h03B70101, 16'h0441, 3'd1, {$urandom, 16'($urandom)}, 1'b0, "R11");
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      chk(!done && !prg_clr && !req_valid, "R11", "waiting for prg_done",
          {done, prg_clr, req_valid}, 0);
    end
    prg_done = 1'b1;
    begin
      int seen = 0;
      for (int w = 0; w < 5 && seen == 0; w++) begin
        @(negedge clk);
        if (prg_clr) seen = 1;
      end
      chk(seen == 1, "R11", "prg_clr pulse", seen, 1);
    end
    prg_done = 1'b0;
    @(negedge clk);
    chk(!prg_clr, "R11", "prg_clr one cycle", prg_clr, 0);
    @(negedge clk);
    chk(done && ok == exp_ready(eff_b4) && high_cap == exp_hc(eff_b4), "R8", "final result",
        {done, ok, high_cap}, {1'b1, exp_ready(eff_b4), exp_hc(eff_b4)});
  endtask

  task automatic run_sd(input bit via_echo);
    int seen = 0;
    pulse_start();
    serve(6'd12, 32'h0, 16'h0041, 3'd1, 48'h0, 1'b0, "R2");
    serve(6'd0, 32'h0, 16'h0080, 3'd0, 48'h0, 1'b1, "R2");
    serve(6'd8, 32'h1AA, 16'h0001, 3'd1, 48'h0, 1'b0, "R2");
    serve(6'd55, 32'h0, 16'h0001, 3'd1, via_echo ? 48'h37_00_0000_0000 : 48'h00_00_0000_0020,
          1'b0, "R4");
    for (int w = 0; w < 12; w++) begin
      @(negedge clk);
      if (sd_handoff) seen++;
      chk(!req_valid && !done, "R4", "idle after hand-off", {req_valid, done}, 0);
    end
    chk(seen == 1, "R4", "hand-off strobe count", seen, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!req_valid && !done && !ok && !high_cap && !prg_clr && !sd_handoff && clk_div == 4'd7,
            "R1", "reset state",
            {req_valid, done, ok, high_cap, prg_clr, sd_handoff, clk_div}, {6'd0, 4'd7});
        run_mmc(3, 8'hC0, 5, 1'b0, 1'b1);
        run_mmc(0, 8'hE0, 0, 1'b0, 1'b0);
        run_sd(1'b0);
        run_sd(1'b1);
        for (int k = 0; k < 6; k++)
          run_mmc($urandom_range(0, 12), 8'h80 | 8'($urandom), $urandom_range(0, 6), 1'b1, 1'b0);
        run_mmc(1000, 8'h00, 0, 1'b0, 1'b0);  // R6: poll never succeeds
        chk(!ok, "R6", "exhausted poll reports fail", ok, 0);
      end
      begin
        repeat (190000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule